// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single counting channel of a programmable interval timer. A byte-wide write port takes two kinds of write: a control word, which picks one of four operating modes and either binary or four-digit BCD counting, and an initial count, which arrives as a low byte and then a high byte. Once both bytes of the count are written, the channel is armed. It then counts CLK edges, qualified by a GATE input, and shapes an OUT waveform that depends on the mode. The four modes are: a level that rises at terminal count, a retriggerable one-shot pulse, a one-clock rate pulse, and a square wave.

Software reads the OUT level and the programmed setup from a status byte. Whenever a count value of zero is written, it stands for the largest count in the selected radix.

Top module: `interval_timer_channel`

## Requirements
- R1: After reset, OUT is low, the status byte is 0x00, and the channel is not armed, so GATE activity leaves OUT low.
- R2: A write with wr_addr=1 is a control word. Bits[5:4] are the access field and bits[3:1] are the mode field. The word is ignored when the access field is 00 or when the mode field is 4 to 7. An accepted word disarms the channel, resets the byte order so the next count write is the low byte, and sets OUT to low for mode 0 or high for modes 1 to 3 at the capturing edge.
- R3: Writes with wr_addr=0 carry the count, low byte first and high byte second. The edge that captures the high byte loads the count and arms the channel.
- R4: Mode 0: OUT is low after loading. It rises after N gated clock edges and then stays high until the next write.
- R5: Mode 0: clock edges with GATE low do not count.
- R6: Mode 1: OUT stays high after loading. A GATE rising edge drives OUT low at that edge, and OUT returns high N edges later. A new rising edge during the pulse restarts the full length N.
- R7: Mode 2 (N≥2): OUT is low for one clock in every N. While GATE is low, OUT is high and counting halts. A GATE rising edge reloads the count.
- R8: Mode 3 (N≥2): OUT is a square wave of period N, high for (N+1)/2 clocks and low for N/2 clocks (integer division). GATE affects it as in R7.
- R9: Control bit 0 set selects BCD. The count is then read as four BCD digits, high byte holding the thousands and hundreds.
- R10: A written count of 0 means 65536 in binary and 10000 in BCD.
- R11: Status byte: bit 7 is the OUT level, bits[3:1] the active mode, bit 0 the BCD flag, and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | 1 | 0 selects the count, 1 the control word |
| wr_data | input | BYTE_W | Write byte |
| gate | input | 1 | Counting qualifier and trigger input |
| out_level | output | 1 | Timer output waveform |
| status | output | BYTE_W | OUT level and programmed setup |

## Verification
Every OUT change, and the status byte that follows it, comes from a register updated at a rising edge. A change is therefore due at the edge that captures the write, the gate change or the counting tick, and never later. The bench drives inputs and samples outputs on the falling edge. Each edge's result is compared in the half cycle after that edge against a behavioural model that advances once per rising edge. The directed checks count falling-edge samples from the loading or triggering edge. This gives exact pulse lengths: N for mode 0 and mode 1, one low sample in N for mode 2, and a split of the period into (N+1)/2 high and N/2 low samples for mode 3.

// File: rtl/itc_pkg.sv
package itc_pkg;

    typedef enum logic [1:0] {
        MODE_TC_LEVEL = 2'd0,
        MODE_ONE_SHOT = 2'd1,
        MODE_RATE     = 2'd2,
        MODE_SQUARE   = 2'd3
    } itc_mode_e;

    // Control word field positions; the bench and the checker decode the same bits.
    localparam int CW_BCD_BIT   = 0;
    localparam int CW_MODE_LO   = 1;
    localparam int CW_MODE_W    = 3;
    localparam int CW_ACCESS_LO = 4;
    localparam int CW_ACCESS_W  = 2;

endpackage

// File: rtl/itc_ctrl_decode.sv
module itc_ctrl_decode
    import itc_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic                ctrl_take,
    output itc_mode_e           ctrl_mode,
    output itc_mode_e           mode,
    output logic                bcd,
    output logic                load_take,
    output logic [2*BYTE_W-1:0] load_value
);

    typedef struct packed {
        itc_mode_e         mode;
        logic              bcd;
        logic              hi_next;
        logic [BYTE_W-1:0] lo_byte;
    } dec_st_t;

    dec_st_t st_d, st_q;

    logic [CW_ACCESS_W-1:0] access_f;
    logic [CW_MODE_W-1:0]   mode_f;

    assign access_f = wr_data[CW_ACCESS_LO +: CW_ACCESS_W];
    assign mode_f   = wr_data[CW_MODE_LO +: CW_MODE_W];

    always_comb begin
        st_d       = st_q;
        ctrl_take  = wr_en && wr_addr && (access_f != '0) && (mode_f[CW_MODE_W-1] == 1'b0);
        ctrl_mode  = itc_mode_e'(mode_f[1:0]);
        load_take  = wr_en && !wr_addr && st_q.hi_next;
        load_value = {wr_data, st_q.lo_byte};

        if (ctrl_take) begin
            st_d.mode    = ctrl_mode;
            st_d.bcd     = wr_data[CW_BCD_BIT];
            st_d.hi_next = 1'b0;
        end else if (wr_en && !wr_addr) begin
            if (st_q.hi_next) begin
                st_d.hi_next = 1'b0;
            end else begin
                st_d.lo_byte = wr_data;
                st_d.hi_next = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_TC_LEVEL, bcd: 1'b0, hi_next: 1'b0, lo_byte: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;
    assign bcd  = st_q.bcd;

endmodule

// File: rtl/itc_gate_edge.sv
module itc_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic gate_rise
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d    = gate;
        gate_rise = gate && !prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/itc_count_core.sv
module itc_count_core
    import itc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate,
    input  logic             gate_rise,
    input  itc_mode_e        mode,
    input  logic             bcd,
    input  logic             ctrl_take,
    input  itc_mode_e        ctrl_mode,
    input  logic             load_take,
    input  logic [CNT_W-1:0] load_value,
    output logic             out_level,
    output logic             armed
);

    localparam int DIGITS = CNT_W / 4;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        logic             out;
        logic             armed;
        logic             run;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [CNT_W-1:0] dec_1, dec_2, dec_3, sq_next;

    // One step down in the selected radix; zero wraps to the top value.
    function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v, input logic in_bcd);
        logic [CNT_W-1:0] r;
        logic             borrow;
        if (!in_bcd) begin
            r = v - CNT_W'(1);
        end else begin
            r      = v;
            borrow = 1'b1;
            for (int i = 0; i < DIGITS; i++) begin
                if (borrow) begin
                    if (v[4*i +: 4] == 4'd0) begin
                        r[4*i +: 4] = 4'd9;
                    end else begin
                        r[4*i +: 4] = v[4*i +: 4] - 4'd1;
                        borrow      = 1'b0;
                    end
                end
            end
        end
        return r;
    endfunction

    always_comb begin
        dec_1 = step_down(st_q.cnt, bcd);
        dec_2 = step_down(dec_1, bcd);
        dec_3 = step_down(dec_2, bcd);
        // Odd value only at the start of a half period: take 1 (high) or 3 (low) once.
        if (st_q.cnt[0]) begin
            sq_next = st_q.out ? dec_1 : dec_3;
        end else begin
            sq_next = dec_2;
        end
    end

    always_comb begin
        st_d = st_q;
        if (ctrl_take) begin
            st_d.armed = 1'b0;
            st_d.run   = 1'b0;
            st_d.out   = (ctrl_mode != MODE_TC_LEVEL);
        end else if (load_take) begin
            st_d.reload = load_value;
            st_d.cnt    = load_value;
            st_d.armed  = 1'b1;
            st_d.run    = (mode == MODE_TC_LEVEL);
            st_d.out    = (mode != MODE_TC_LEVEL);
        end else if (st_q.armed) begin
            unique case (mode)
                MODE_TC_LEVEL: begin
                    if (st_q.run && gate) begin
                        st_d.cnt = dec_1;
                        if (dec_1 == '0) begin
                            st_d.out = 1'b1;
                            st_d.run = 1'b0;
                        end
                    end
                end
                MODE_ONE_SHOT: begin
                    if (gate_rise) begin
                        st_d.cnt = st_q.reload;
                        st_d.out = 1'b0;
                        st_d.run = 1'b1;
                    end else if (st_q.run) begin
                        st_d.cnt = dec_1;
                        if (dec_1 == '0) begin
                            st_d.out = 1'b1;
                            st_d.run = 1'b0;
                        end
                    end
                end
                MODE_RATE: begin
                    if (!gate) begin
                        st_d.out = 1'b1;
                    end else if (gate_rise) begin
                        st_d.cnt = st_q.reload;
                        st_d.out = 1'b1;
                    end else if (st_q.cnt == CNT_W'(1)) begin
                        st_d.cnt = st_q.reload;
                        st_d.out = 1'b0;
                    end else begin
                        st_d.cnt = dec_1;
                        st_d.out = 1'b1;
                    end
                end
                MODE_SQUARE: begin
                    if (!gate) begin
                        st_d.out = 1'b1;
                    end else if (gate_rise) begin
                        st_d.cnt = st_q.reload;
                        st_d.out = 1'b1;
                    end else if (sq_next == '0) begin
                        st_d.cnt = st_q.reload;
                        st_d.out = !st_q.out;
                    end else begin
                        st_d.cnt = sq_next;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, reload: '0, out: 1'b0, armed: 1'b0, run: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_level = st_q.out;
    assign armed     = st_q.armed;

endmodule

// File: rtl/interval_timer_channel.sv
module interval_timer_channel
    import itc_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              gate,
    output logic              out_level,
    output logic [BYTE_W-1:0] status
);

    localparam int CNT_W = 2 * BYTE_W;

    logic              ctrl_take, load_take, bcd, gate_rise, armed;
    itc_mode_e         ctrl_mode, mode;
    logic [CNT_W-1:0]  load_value;

    itc_ctrl_decode #(.BYTE_W(BYTE_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ctrl_take  (ctrl_take),
        .ctrl_mode  (ctrl_mode),
        .mode       (mode),
        .bcd        (bcd),
        .load_take  (load_take),
        .load_value (load_value)
    );

    itc_gate_edge u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate      (gate),
        .gate_rise (gate_rise)
    );

    itc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate       (gate),
        .gate_rise  (gate_rise),
        .mode       (mode),
        .bcd        (bcd),
        .ctrl_take  (ctrl_take),
        .ctrl_mode  (ctrl_mode),
        .load_take  (load_take),
        .load_value (load_value),
        .out_level  (out_level),
        .armed      (armed)
    );

    always_comb begin
        status                                = '0;
        status[BYTE_W-1]                      = out_level;
        status[CW_MODE_LO +: CW_MODE_W]       = {1'b0, mode};
        status[CW_BCD_BIT]                    = bcd;
    end

endmodule

// File: rtl/itc_checker.sv
module itc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_addr,
    input logic [5:1] cw_bits,
    input logic       gate,
    input logic       out_level,
    input logic [3:0] stat_lo,
    input logic       armed
);

    logic cw_write, cw_ok, cw_bad;
    assign cw_write = wr_en && wr_addr;
    assign cw_ok    = cw_write && (cw_bits[5:4] != 2'b00) && !cw_bits[3];
    assign cw_bad   = cw_write && ((cw_bits[5:4] == 2'b00) || cw_bits[3]);

    AST_CW_SETS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        cw_ok |=> (out_level == ($past(cw_bits[2:1]) != 2'd0))); // R2

    AST_CW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        cw_bad |=> $stable(stat_lo)); // R2

    AST_M0_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_lo[3:1] == 3'd0) && out_level && !wr_en |=> out_level); // R4

    AST_M0_GATE_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_lo[3:1] == 3'd0) && !gate && !wr_en |=> $stable(out_level)); // R5

    AST_M1_TRIGGER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_lo[3:1] == 3'd1) && armed && gate && !$past(gate) && !wr_en |=> !out_level); // R6

    AST_PERIODIC_GATE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_lo[3:1] == 3'd2) || (stat_lo[3:1] == 3'd3)) && !gate && !wr_en |=> out_level); // R7

endmodule

bind interval_timer_channel itc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .cw_bits   (wr_data[5:1]),
    .gate      (gate),
    .out_level (out_level),
    .stat_lo   (status[3:0]),
    .armed     (armed)
);

// File: tb/tb_interval_timer_channel.sv
module tb_interval_timer_channel;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       gate = 1'b0;
    logic       out_level;
    logic [7:0] status;

    interval_timer_channel dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .gate(gate), .out_level(out_level), .status(status)
    );

    always #(CLK_PERIOD/2) clk = !clk;

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference ----------------
    int m_mode = 0, m_bcd = 0, m_hi = 0, m_lo = 0, m_n = 1, m_rem = 0, m_ph = 0;
    bit m_out = 0, m_armed = 0, m_run = 0, m_gprev = 0;

    function automatic int count_of(input int raw, input int in_bcd);
        int v;
        if (in_bcd != 0)
            v = ((raw >> 12) & 15) * 1000 + ((raw >> 8) & 15) * 100 + ((raw >> 4) & 15) * 10 + (raw & 15);
        else
            v = raw;
        if (v == 0) v = (in_bcd != 0) ? 10000 : 65536;
        return v;
    endfunction

    always @(posedge clk) begin
        bit rise;
        int half;
        rise = gate && !m_gprev;
        if (!rst_n) begin
            m_mode = 0; m_bcd = 0; m_hi = 0; m_out = 0; m_armed = 0; m_run = 0; m_gprev = 0;
        end else begin
            if (wr_en && wr_addr) begin
                if (wr_data[5:4] != 2'b00 && !wr_data[3]) begin
                    m_mode = int'(wr_data[2:1]); m_bcd = int'(wr_data[0]);
                    m_hi = 0; m_armed = 0; m_run = 0; m_out = (m_mode != 0);
                end
            end else if (wr_en && m_hi == 0) begin
                m_lo = int'(wr_data); m_hi = 1;
            end else if (wr_en) begin
                m_hi = 0;
                m_n = count_of(int'(wr_data) * 256 + m_lo, m_bcd);
                m_armed = 1; m_rem = m_n; m_ph = 0;
                m_run = (m_mode == 0); m_out = (m_mode != 0);
            end else if (m_armed) begin
                case (m_mode)
                    0: if (m_run && gate) begin
                           m_rem--;
                           if (m_rem == 0) begin m_out = 1; m_run = 0; end
                       end
                    1: if (rise) begin
                           m_rem = m_n; m_out = 0; m_run = 1;
                       end else if (m_run) begin
                           m_rem--;
                           if (m_rem == 0) begin m_out = 1; m_run = 0; end
                       end
                    2: if (!gate) m_out = 1;
                       else if (rise) begin m_ph = 0; m_out = 1; end
                       else begin
                           m_ph++;
                           if (m_ph == m_n) begin m_ph = 0; m_out = 0; end
                           else m_out = 1;
                       end
                    default: if (!gate) m_out = 1;
                       else if (rise) begin m_ph = 0; m_out = 1; end
                       else begin
                           half = m_out ? (m_n + 1) / 2 : m_n / 2;
                           m_ph++;
                           if (m_ph == half) begin m_ph = 0; m_out = !m_out; end
                       end
                endcase
            end
            m_gprev = gate;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic cyc();
        @(negedge clk);
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
        if (rst_n) begin
            check(out_level == m_out, cur_req, "out_level", int'(out_level), int'(m_out));
            check(status == 8'((int'(m_out) << 7) | (m_mode << 1) | m_bcd), cur_req, "status",
                  int'(status), (int'(m_out) << 7) | (m_mode << 1) | m_bcd);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic load(input logic [7:0] cw, input logic [15:0] n);
        wr(1'b1, cw);
        wr(1'b0, n[7:0]);
        wr(1'b0, n[15:8]);
    endtask

    task automatic wait_out(input logic lvl, input int limit, output int n);
        n = 0;
        while (out_level !== lvl && n < limit) begin
            cyc();
            n++;
        end
    endtask

    task automatic count_low(input int len, output int lows);
        lows = 0;
        for (int i = 0; i < len; i++) begin
            cyc();
            if (!out_level) lows++;
        end
    endtask

    initial begin
        int n;
        int k;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check(out_level == 1'b0, "R1", "reset out", int'(out_level), 0);
        check(status == 8'h00, "R1", "reset status", int'(status), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin gate = i[0]; cyc(); end
        check(out_level == 1'b0, "R1", "unarmed out after gate toggles", int'(out_level), 0);

        // R2: access field 00, then mode field 5, are both ignored
        cur_req = "R2";
        wr(1'b1, 8'h04);
        cyc();
        check(status == 8'h00, "R2", "access 00 ignored", int'(status), 0);
        wr(1'b1, 8'h3A);
        cyc();
        check(status == 8'h00, "R2", "mode 5 ignored", int'(status), 0);

        // R3/R4: mode 0, binary count 5
        cur_req = "R4";
        gate = 1'b1;
        load(8'h30, 16'd5);
        check(out_level == 1'b0, "R3", "mode 0 low after load", int'(out_level), 0);
        wait_out(1'b1, 100, n);
        check(n == 5, "R4", "mode 0 edges to high", n, 5);
        repeat (8) cyc();
        check(out_level == 1'b1, "R4", "mode 0 stays high", int'(out_level), 1);

        // R5: gate low pauses mode 0
        cur_req = "R5";
        load(8'h30, 16'd6);
        cyc(); cyc();
        gate = 1'b0;
        cyc(); cyc(); cyc();
        check(out_level == 1'b0, "R5", "paused mode 0 still low", int'(out_level), 0);
        gate = 1'b1;
        wait_out(1'b1, 100, n);
        check(n == 4, "R5", "remaining edges after pause", n, 4);

        // R6: one-shot of length 4 with retrigger
        cur_req = "R6";
        gate = 1'b0;
        load(8'h32, 16'd4);
        cyc(); cyc();
        check(out_level == 1'b1, "R6", "one-shot idle high", int'(out_level), 1);
        gate = 1'b1;
        cyc();
        check(out_level == 1'b0, "R6", "trigger edge drives low", int'(out_level), 0);
        wait_out(1'b1, 100, n);
        check(n == 4, "R6", "pulse length", n, 4);
        gate = 1'b0; cyc();
        gate = 1'b1; cyc();
        cyc(); cyc();
        gate = 1'b0; cyc();
        gate = 1'b1; cyc();
        wait_out(1'b1, 100, n);
        check(n == 4, "R6", "retrigger restarts full length", n, 4);

        // R7: rate pulses, period 4
        cur_req = "R7";
        load(8'h34, 16'd4);
        count_low(20, k);
        check(k == 5, "R7", "low samples in 20 clocks", k, 5);
        gate = 1'b0;
        for (int i = 0; i < 3; i++) begin
            cyc();
            check(out_level == 1'b1, "R7", "gate low forces high", int'(out_level), 1);
        end
        gate = 1'b1;
        cyc();
        wait_out(1'b0, 100, n);
        check(n == 4, "R7", "edges to pulse after gate reload", n, 4);

        // R8: square wave, odd then even count
        cur_req = "R8";
        load(8'h36, 16'd5);
        count_low(20, k);
        check(k == 8, "R8", "odd count low samples in 20", k, 8);
        wr(1'b0, 8'd4);
        wr(1'b0, 8'd0);
        count_low(20, k);
        check(k == 10, "R8", "even count low samples in 20", k, 10);
        gate = 1'b0;
        cyc(); cyc();
        check(out_level == 1'b1, "R8", "gate low forces high", int'(out_level), 1);
        gate = 1'b1;

        // R9: BCD count 12 in mode 2
        cur_req = "R9";
        load(8'h35, 16'h0012);
        count_low(36, k);
        check(k == 3, "R9", "BCD period 12 lows in 36", k, 3);

        // R11: status layout
        cur_req = "R11";
        wr(1'b1, 8'h37);
        check(status == 8'h87, "R11", "status for square BCD", int'(status), 8'h87);
        wr(1'b1, 8'h31);
        check(status == 8'h01, "R11", "status for mode 0 BCD", int'(status), 8'h01);

        // R10: zero count in both radixes
        cur_req = "R10";
        wr(1'b0, 8'h00);
        wr(1'b0, 8'h00);
        wait_out(1'b1, 20000, n);
        check(n == 10000, "R10", "BCD zero count length", n, 10000);
        load(8'h30, 16'd0);
        wait_out(1'b1, 70000, n);
        check(n == 65536, "R10", "binary zero count length", n, 65536);

        // R2: new control word disarms a running rate generator
        cur_req = "R2";
        load(8'h34, 16'd3);
        cyc(); cyc();
        wr(1'b1, 8'h30);
        check(out_level == 1'b0, "R2", "control word sets mode 0 level", int'(out_level), 0);
        for (int i = 0; i < 10; i++) begin gate = i[0]; cyc(); end
        check(out_level == 1'b0, "R2", "disarmed output unchanged", int'(out_level), 0);
        wr(1'b1, 8'h36);
        check(out_level == 1'b1, "R2", "control word sets mode 3 level", int'(out_level), 1);

        finish_run();
    end

endmodule